// File: doc/BRIEF.md
# Tick-Amortized Disciplined Nanosecond Clock

This block keeps time of day as a seconds count and a nanoseconds count. A tick generator divides the core clock into a fixed number of ticks per second. At every tick the stored time advances by a per-tick increment. Between ticks a read adds the cycles elapsed since the last tick, scaled to nanoseconds, so reads resolve finer than the tick period.

A discipline loop outside the block loads a phase correction, a frequency correction and a shift exponent. Each time the tick count closes a full second, the block works out the next second's length. That length is the nominal second plus the frequency correction plus a share of the pending phase. The share is the pending phase shifted right by the exponent, and the pending phase is reduced by the same share. The per-tick increment is that length divided by the number of ticks. The remainder is spread with a fractional accumulator, so the whole second adds exactly the computed length.

A read port returns a registered timestamp one cycle after a request. The timestamp never goes backwards, even when a slow-running second makes the fresh tick value fall below an interpolated value read just before it.

Top module: `amortized_ns_clock`

## Requirements
- R1: After synchronous reset the stored time, the pending phase, the frequency correction and the read outputs are zero, and `rd_valid` is low. A read on the first cycle after reset returns 0 s 0 ns.
- R2: With no correction loaded, a read sampled N cycles after reset returns N × NS_PER_CYC nanoseconds in total. A tick fires every CYC_PER_TICK cycles and adds 1e9 / TICKS_PER_SEC ns. Between ticks, the interpolation adds (cycles since the tick) × NS_PER_CYC, where NS_PER_CYC = (1e9 / TICKS_PER_SEC) / CYC_PER_TICK.
- R3: The nanoseconds field never exceeds 999,999,999. A sum that reaches 1e9 wraps and carries one into seconds. This holds both for the stored time at a tick and for the interpolated value formed by a read.
- R4: `rd_req` is sampled at a clock edge. `rd_valid` is high for exactly the following cycle, and the timestamp reflects the state before that edge.
- R5: `load_en` captures `phase_in`, `freq_in` and `shift_k` (k, 0..15). They change no tick increment until the next second boundary, which is the tick that completes each group of TICKS_PER_SEC ticks.
- R6: At a second boundary the phase share is `pending >>> k` (arithmetic shift, rounding toward minus infinity). The pending phase drops by that share, and the next second's length is 1e9 + freq + share ns. The boundary tick itself still uses the old increment.
- R7: During a second, each tick adds floor(length / TICKS_PER_SEC) ns, plus 1 ns whenever the fractional accumulator carries. The first tick of a second with an accumulator at zero adds exactly the floor value, and the whole second adds exactly the length.
- R8: If the interpolated value of a read is smaller than the last value returned, the read returns the last value plus 1 ns instead (with nanosecond wrap).
- R9: The phase left after one boundary is shared again at later boundaries, so a second boundary uses the reduced pending value. With k = 0 the whole phase is applied in one second and nothing remains.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Capture the correction inputs this cycle |
| phase_in | input | CORR_W | Signed phase correction, ns |
| freq_in | input | CORR_W | Signed frequency correction, ns per second |
| shift_k | input | SHIFT_W | Exponent k of the phase share 2^-k |
| rd_req | input | 1 | Read request |
| rd_valid | output | 1 | Read result valid, one cycle after the request |
| rd_sec | output | SEC_W | Returned seconds |
| rd_ns | output | NS_W | Returned nanoseconds, 0..999,999,999 |

## Verification
The bench builds the block with 8 ticks per second and 16 cycles per tick. A second therefore lasts 128 cycles, and one cycle is exactly 7,812,500 ns, so every expected timestamp is a whole-number product of the cycle count. This puts several second boundaries within a few hundred cycles. Corrections that leave a nonzero remainder over 8 ticks exercise the fractional accumulator. A frequency correction of −80 ms per second makes a tick land below the last interpolated value, which triggers the monotonic guard. Negative phase with k = 0 drives both the stored-time wrap and the read-path wrap.

// File: rtl/dnc_pkg.sv
package dnc_pkg;
  // Nanoseconds in one second; the nanosecond field wraps here.
  localparam int unsigned NS_PER_SEC = 1_000_000_000;
endpackage

// File: rtl/dnc_tick_gen.sv
module dnc_tick_gen #(
  parameter int CYC_PER_TICK = 244140,
  parameter int CYC_W        = 18,
  parameter int TICK_LG2     = 10
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CYC_W-1:0] cyc_cnt,
  output logic             tick,
  output logic             sec_edge
);
  localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(CYC_PER_TICK - 1);

  logic [TICK_LG2-1:0] tick_idx;

  assign tick     = (cyc_cnt == CYC_LAST);
  assign sec_edge = tick && (tick_idx == '1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc_cnt  <= '0;
      tick_idx <= '0;
    end else if (tick) begin
      cyc_cnt  <= '0;
      tick_idx <= tick_idx + 1'b1;
    end else begin
      cyc_cnt  <= cyc_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/dnc_rate_calc.sv
module dnc_rate_calc
  import dnc_pkg::*;
#(
  parameter int CORR_W   = 32,
  parameter int SHIFT_W  = 4,
  parameter int TICK_LG2 = 10,
  parameter int NS_W     = 30
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load_en,
  input  logic signed [CORR_W-1:0] phase_in,
  input  logic signed [CORR_W-1:0] freq_in,
  input  logic [SHIFT_W-1:0]       shift_k,
  input  logic                     sec_edge,
  output logic [NS_W-1:0]          inc_whole,
  output logic [TICK_LG2-1:0]      inc_frac,
  output logic signed [CORR_W-1:0] pend
);
  localparam int TOT_W = CORR_W + 2;
  localparam logic [NS_W-1:0]     NOM_WHOLE = NS_W'(NS_PER_SEC >> TICK_LG2);
  localparam logic [TICK_LG2-1:0] NOM_FRAC  = TICK_LG2'(NS_PER_SEC % (1 << TICK_LG2));

  logic signed [CORR_W-1:0] freq_reg;
  logic [SHIFT_W-1:0]       k_reg;
  logic signed [CORR_W-1:0] share;
  logic signed [TOT_W-1:0]  sec_len;
  logic signed [TOT_W-1:0]  scaled;
  logic                     unused_hi;

  // Phase share for the coming second: floor(pend / 2^k).
  assign share   = pend >>> k_reg;
  assign sec_len = $signed(TOT_W'(NS_PER_SEC)) + TOT_W'(freq_reg) + TOT_W'(share);
  assign scaled  = sec_len >>> TICK_LG2;
  assign unused_hi = ^scaled[TOT_W-1:NS_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      pend      <= '0;
      freq_reg  <= '0;
      k_reg     <= '0;
      inc_whole <= NOM_WHOLE;
      inc_frac  <= NOM_FRAC;
    end else begin
      if (sec_edge) begin
        inc_whole <= scaled[NS_W-1:0];
        inc_frac  <= sec_len[TICK_LG2-1:0];
      end
      if (load_en) begin
        pend     <= phase_in;
        freq_reg <= freq_in;
        k_reg    <= shift_k;
      end else if (sec_edge) begin
        pend <= pend - share;
      end
    end
  end
endmodule

// File: rtl/dnc_time_acc.sv
module dnc_time_acc
  import dnc_pkg::*;
#(
  parameter int SEC_W    = 32,
  parameter int NS_W     = 30,
  parameter int TICK_LG2 = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic [NS_W-1:0]     inc_whole,
  input  logic [TICK_LG2-1:0] inc_frac,
  output logic [SEC_W-1:0]    base_sec,
  output logic [NS_W-1:0]     base_ns
);
  localparam logic [NS_W:0] NS_LIM = (NS_W+1)'(NS_PER_SEC);

  logic [TICK_LG2-1:0] frac_acc;
  logic [TICK_LG2:0]   frac_sum;
  logic [NS_W:0]       ns_sum;

  assign frac_sum = {1'b0, frac_acc} + {1'b0, inc_frac};
  assign ns_sum   = {1'b0, base_ns} + {1'b0, inc_whole} + {{NS_W{1'b0}}, frac_sum[TICK_LG2]};

  always_ff @(posedge clk) begin
    if (rst) begin
      base_sec <= '0;
      base_ns  <= '0;
      frac_acc <= '0;
    end else if (tick) begin
      frac_acc <= frac_sum[TICK_LG2-1:0];
      if (ns_sum >= NS_LIM) begin
        base_ns  <= NS_W'(ns_sum - NS_LIM);
        base_sec <= base_sec + 1'b1;
      end else begin
        base_ns  <= ns_sum[NS_W-1:0];
      end
    end
  end
endmodule

// File: rtl/dnc_read_port.sv
module dnc_read_port
  import dnc_pkg::*;
#(
  parameter int SEC_W      = 32,
  parameter int NS_W       = 30,
  parameter int CYC_W      = 18,
  parameter int NS_PER_CYC = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_req,
  input  logic [SEC_W-1:0] base_sec,
  input  logic [NS_W-1:0]  base_ns,
  input  logic [CYC_W-1:0] cyc_cnt,
  output logic             rd_valid,
  output logic [SEC_W-1:0] rd_sec,
  output logic [NS_W-1:0]  rd_ns
);
  localparam logic [NS_W:0]   NS_LIM = (NS_W+1)'(NS_PER_SEC);
  localparam logic [NS_W-1:0] NS_TOP = NS_W'(NS_PER_SEC - 1);

  logic [NS_W-1:0]  interp;
  logic [NS_W:0]    cand_sum;
  logic [SEC_W-1:0] cand_sec;
  logic [NS_W-1:0]  cand_ns;
  logic             below;

  assign interp   = NS_W'(cyc_cnt) * NS_W'(NS_PER_CYC);
  assign cand_sum = {1'b0, base_ns} + {1'b0, interp};

  always_comb begin
    if (cand_sum >= NS_LIM) begin
      cand_sec = base_sec + 1'b1;
      cand_ns  = NS_W'(cand_sum - NS_LIM);
    end else begin
      cand_sec = base_sec;
      cand_ns  = cand_sum[NS_W-1:0];
    end
    below = (cand_sec < rd_sec) || ((cand_sec == rd_sec) && (cand_ns < rd_ns));
  end

  // rd_sec/rd_ns hold the last value returned; they are the floor for the next read.
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_sec   <= '0;
      rd_ns    <= '0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) begin
        if (!below) begin
          rd_sec <= cand_sec;
          rd_ns  <= cand_ns;
        end else if (rd_ns == NS_TOP) begin
          rd_sec <= rd_sec + 1'b1;
          rd_ns  <= '0;
        end else begin
          rd_ns  <= rd_ns + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/amortized_ns_clock.sv
module amortized_ns_clock
  import dnc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 1024,
  parameter int CYC_PER_TICK  = 244140,
  parameter int SEC_W         = 32,
  parameter int NS_W          = 30,
  parameter int CORR_W        = 32,
  parameter int SHIFT_W       = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load_en,
  input  logic signed [CORR_W-1:0] phase_in,
  input  logic signed [CORR_W-1:0] freq_in,
  input  logic [SHIFT_W-1:0]       shift_k,
  input  logic                     rd_req,
  output logic                     rd_valid,
  output logic [SEC_W-1:0]         rd_sec,
  output logic [NS_W-1:0]          rd_ns
);
  localparam int TICK_LG2    = $clog2(TICKS_PER_SEC);
  localparam int CYC_W       = $clog2(CYC_PER_TICK);
  localparam int NOM_TICK_NS = int'(NS_PER_SEC) / TICKS_PER_SEC;
  localparam int NS_PER_CYC  = NOM_TICK_NS / CYC_PER_TICK;

  logic [CYC_W-1:0]         cyc_cnt;
  logic                     tick;
  logic                     sec_edge;
  logic [NS_W-1:0]          inc_whole;
  logic [TICK_LG2-1:0]      inc_frac;
  logic signed [CORR_W-1:0] pend_w;
  logic [SEC_W-1:0]         base_sec_w;
  logic [NS_W-1:0]          base_ns_w;

  dnc_tick_gen #(
    .CYC_PER_TICK(CYC_PER_TICK), .CYC_W(CYC_W), .TICK_LG2(TICK_LG2)
  ) u_tick (
    .clk(clk), .rst(rst), .cyc_cnt(cyc_cnt), .tick(tick), .sec_edge(sec_edge)
  );

  dnc_rate_calc #(
    .CORR_W(CORR_W), .SHIFT_W(SHIFT_W), .TICK_LG2(TICK_LG2), .NS_W(NS_W)
  ) u_rate (
    .clk(clk), .rst(rst), .load_en(load_en), .phase_in(phase_in), .freq_in(freq_in),
    .shift_k(shift_k), .sec_edge(sec_edge), .inc_whole(inc_whole), .inc_frac(inc_frac),
    .pend(pend_w)
  );

  dnc_time_acc #(
    .SEC_W(SEC_W), .NS_W(NS_W), .TICK_LG2(TICK_LG2)
  ) u_time (
    .clk(clk), .rst(rst), .tick(tick), .inc_whole(inc_whole), .inc_frac(inc_frac),
    .base_sec(base_sec_w), .base_ns(base_ns_w)
  );

  dnc_read_port #(
    .SEC_W(SEC_W), .NS_W(NS_W), .CYC_W(CYC_W), .NS_PER_CYC(NS_PER_CYC)
  ) u_read (
    .clk(clk), .rst(rst), .rd_req(rd_req), .base_sec(base_sec_w), .base_ns(base_ns_w),
    .cyc_cnt(cyc_cnt), .rd_valid(rd_valid), .rd_sec(rd_sec), .rd_ns(rd_ns)
  );
endmodule

// File: rtl/ns_clock_chk.sv
module ns_clock_chk
  import dnc_pkg::*;
#(
  parameter int SEC_W  = 32,
  parameter int NS_W   = 30,
  parameter int CORR_W = 32
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     rd_valid,
  input logic [SEC_W-1:0]         rd_sec,
  input logic [NS_W-1:0]          rd_ns,
  input logic                     load_en,
  input logic signed [CORR_W-1:0] pend,
  input logic [SEC_W-1:0]         base_sec
);
  localparam logic [NS_W-1:0] NS_TOP = NS_W'(NS_PER_SEC - 1);

  logic [SEC_W-1:0] prev_sec;
  logic [NS_W-1:0]  prev_ns;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_sec <= '0;
      prev_ns  <= '0;
    end else if (rd_valid) begin
      prev_sec <= rd_sec;
      prev_ns  <= rd_ns;
    end
  end

  function automatic logic [CORR_W:0] mag(input logic signed [CORR_W-1:0] v);
    logic signed [CORR_W:0] w;
    w = {v[CORR_W-1], v};
    return (w < 0) ? $unsigned(-w) : $unsigned(w);
  endfunction

  // R3
  ns_range_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> rd_ns <= NS_TOP);

  // R8
  read_monotonic_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> {rd_sec, rd_ns} >= {prev_sec, prev_ns});

  // R9
  pending_shrinks_chk: assert property (@(posedge clk) disable iff (rst)
    !load_en |=> mag(pend) <= mag($past(pend)));

  // R2
  sec_no_backstep_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> base_sec >= $past(base_sec));
endmodule

bind amortized_ns_clock ns_clock_chk #(
  .SEC_W(SEC_W), .NS_W(NS_W), .CORR_W(CORR_W)
) u_chk (
  .clk(clk), .rst(rst), .rd_valid(rd_valid), .rd_sec(rd_sec), .rd_ns(rd_ns),
  .load_en(load_en), .pend(pend_w), .base_sec(base_sec_w)
);

// File: tb/amortized_ns_clock_tb.sv
module amortized_ns_clock_tb;
  localparam int TPS = 8;
  localparam int CPT = 16;
  localparam longint NPC = 64'd7812500;
  localparam longint GIGA = 64'd1000000000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic load_en = 1'b0;
  logic signed [31:0] phase_in = '0;
  logic signed [31:0] freq_in = '0;
  logic [3:0] shift_k = '0;
  logic rd_req = 1'b0;
  logic rd_valid;
  logic [31:0] rd_sec;
  logic [29:0] rd_ns;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  int unsigned m;

  always #2 clk = ~clk;

  amortized_ns_clock #(
    .TICKS_PER_SEC(TPS), .CYC_PER_TICK(CPT), .SEC_W(32), .NS_W(30), .CORR_W(32), .SHIFT_W(4)
  ) u_dut (
    .clk(clk), .rst(rst), .load_en(load_en), .phase_in(phase_in), .freq_in(freq_in),
    .shift_k(shift_k), .rd_req(rd_req), .rd_valid(rd_valid), .rd_sec(rd_sec), .rd_ns(rd_ns)
  );

  // Cycles elapsed since reset release, counted at the same edges the design uses.
  always @(posedge clk) begin
    if (rst) m <= 0;
    else     m <= m + 1;
  end

  task automatic check_val(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    rd_req = 1'b0;
    load_en = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic read_at(input int unsigned at, input string tag, input longint exp_total);
    while (m != at) @(negedge clk);
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
    check_val({tag, " rd_valid"}, longint'(rd_valid), 1);
    check_val(tag, longint'(rd_sec) * GIGA + longint'(rd_ns), exp_total);
  endtask

  task automatic load_at(input int unsigned at, input int p, input int f, input int k);
    while (m != at) @(negedge clk);
    load_en = 1'b1;
    phase_in = p;
    freq_in = f;
    shift_k = 4'(k);
    @(negedge clk);
    load_en = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check_val("R1 rd_valid after reset", longint'(rd_valid), 0);
    check_val("R1 rd_sec after reset", longint'(rd_sec), 0);
    check_val("R1 rd_ns after reset", longint'(rd_ns), 0);
    read_at(0, "R1 first read", 0);
  endtask

  task automatic t_nominal();
    do_reset();
    read_at(5, "R2 interpolated read", 5 * NPC);
    @(negedge clk);
    check_val("R4 rd_valid single cycle", longint'(rd_valid), 0);
    read_at(20, "R2 read after a tick", 20 * NPC);
    read_at(127, "R2 last cycle of second", 127 * NPC);
    read_at(128, "R3 ns wraps into seconds", GIGA);
  endtask

  task automatic t_phase_freq();
    do_reset();
    load_at(10, 1000, 5, 2);
    // R5: correction not yet active before the boundary
    read_at(100, "R5 no effect before boundary", 100 * NPC);
    // second 1 length 1e9+5+250; first tick adds floor(/8)
    read_at(144, "R7 first tick share", GIGA + 64'd125000031);
    read_at(256, "R6 second length exact", 2 * GIGA + 64'd255);
    // second 2: share 750>>>2 = 187
    read_at(384, "R9 remaining phase shared", 3 * GIGA + 64'd447);
  endtask

  task automatic t_neg_phase();
    do_reset();
    load_at(10, -1001, 0, 0);
    read_at(256, "R6 negative phase k=0", GIGA + 64'd999998999);
    read_at(257, "R3 read-path wrap", 2 * GIGA + 64'd7811499);
    read_at(384, "R9 nothing left after k=0", 2 * GIGA + 64'd999998999);
  endtask

  task automatic t_monotonic();
    do_reset();
    load_at(10, 0, -80000000, 0);
    read_at(143, "R8 interpolated before tick", GIGA + 15 * NPC);
    read_at(144, "R8 clamped to last plus one", GIGA + 15 * NPC + 1);
    read_at(145, "R8 resumes once above", GIGA + 64'd115000000 + NPC);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_nominal();
    t_phase_freq();
    t_neg_phase();
    t_monotonic();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule